// File: doc/BRIEF.md
# Split Decimal Sign-Magnitude Accumulator

This block holds a signed decimal value of twenty BCD digits. The value is kept as two ten-digit halves, an upper half and a lower half, and both halves share one sign bit. A single-cycle command either adds a signed ten-digit operand to the value or subtracts it. The operand can be aligned with the lower half or with the upper half. The command can also clear the whole value first, or clear one half without touching the other.

To use it, present an operation code, the operand sign and ten operand digits, and raise `start` for one clock. In the next cycle the halves and the sign show the new value, and `done` is high for that one cycle. The halves and the sign are always visible at the outputs. Reading them has no effect on the stored value.

The arithmetic is sign-magnitude over the full twenty digits, so carries and borrows cross the boundary between the halves. An operation on the upper half that reverses the sign rewrites the lower half as its ten's complement and lowers the upper units digit by one. An operand digit that is not valid BCD cancels the command and raises an error flag.

Top module: `accSplitDecimal`

## Requirements
- R1: After reset both halves read zero, the sign is plus (`signOut`=0; 1 means minus), and `done` and `errFlag` are low.
- R2: Each cycle with `start` high is followed by exactly one cycle with `done` high, and the new value appears in that same cycle. A cycle with `start` low changes neither half nor the sign, and the cycle after it has `done` low.
- R3: Code 0x0 adds the operand to the lower half and code 0x1 subtracts it. Both act on the full signed twenty-digit value, so a carry or borrow out of the lower half changes the upper half.
- R4: Code 0x2 adds the operand at the upper-half position and code 0x3 subtracts it. The lower half is left unchanged unless the sign reverses. A carry out of the top digit is discarded.
- R5: When an upper-half operation reverses the sign, the lower half becomes its ten's complement and the upper half's units digit is one lower than a plain upper-half difference would give. A lower half of zero stays zero and gets no reduction.
- R6: Codes 0x4 and 0x5 clear the value to plus zero and then add or subtract the operand into the lower half. Codes 0x6 and 0x7 do the same into the upper half. The half not targeted reads zero afterwards.
- R7: A result of magnitude zero takes the effective operand sign (operand sign XOR subtract). After a clear-first code (0x4 to 0x7) the sign is always plus.
- R8: Code 0x8 zeroes the upper half and code 0x9 zeroes the lower half. The other half and the sign keep their values, and the operand is ignored.
- R9: For codes 0x0 to 0x7, an operand nibble above 9 raises `errFlag` together with `done` and leaves both halves and the sign unchanged.
- R10: Codes 0xA to 0xF pulse `done` and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe |
| opSel | input | 4 | Operation code |
| opSign | input | 1 | Operand sign, 1 = minus |
| opDigits | input | 40 | Ten BCD operand digits, most significant digit first |
| upperOut | output | 40 | Upper half, ten BCD digits |
| lowerOut | output | 40 | Lower half, ten BCD digits |
| signOut | output | 1 | Shared sign, 1 = minus |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Operand was not valid BCD; command suppressed |

## Verification
The operand sequences are chosen so that different outcomes can be told apart:
- a lower-half add whose carry crosses into the upper half;
- a lower-half subtract whose borrow crosses back;
- a subtract that reverses the sign;
- an upper-half subtract that keeps the sign, with a nonzero lower half;
- an upper-half subtract that reverses the sign, run once with a nonzero lower half and once with a zero lower half, which separates the complement-and-reduce rule from a plain difference;
- results of zero magnitude after a plain subtract and after a clear-first code, which expose the two zero-sign rules;
- a full-scale upper-half add, which shows that the top carry is dropped.

Further cases cover half clears, an invalid BCD nibble and unused codes, checking that each of them leaves the untouched state unchanged.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef struct packed {
    logic apply;
    logic resetFirst;
    logic toUpper;
    logic negate;
    logic clrUpper;
    logic clrLower;
  } accStrobes_t;

  localparam logic [3:0] OP_CLR_UPPER = 4'h8;
  localparam logic [3:0] OP_CLR_LOWER = 4'h9;

endpackage

// File: rtl/acc_ctrl.sv
module accCtrl
  import acc_pkg::*;
#(
  parameter int N = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [3:0]      opSel,
  input  logic [4*N-1:0]  opDigits,
  output accStrobes_t     stb,
  output logic            done,
  output logic            errFlag
);

  logic bcdOk;
  logic isArith;

  always_comb begin
    bcdOk = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (opDigits[4*i +: 4] > 4'd9) bcdOk = 1'b0;
    end
  end

  assign isArith = ~opSel[3];

  always_comb begin
    stb            = '0;
    stb.apply      = start & isArith & bcdOk;
    stb.negate     = opSel[0];
    stb.toUpper    = opSel[1];
    stb.resetFirst = opSel[2];
    stb.clrUpper   = start & (opSel == OP_CLR_UPPER);
    stb.clrLower   = start & (opSel == OP_CLR_LOWER);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      done    <= start;
      errFlag <= start & isArith & ~bcdOk;
    end
  end

endmodule

// File: rtl/acc_datapath.sv
module accDatapath
  import acc_pkg::*;
#(
  parameter int N = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  accStrobes_t     stb,
  input  logic            opSign,
  input  logic [4*N-1:0]  opDigits,
  output logic [4*N-1:0]  upperOut,
  output logic [4*N-1:0]  lowerOut,
  output logic            signOut
);

  localparam int HB = 4 * N;
  localparam int TD = 2 * N;
  localparam int BW = 4 * TD;

  function automatic logic [BW:0] bcdAdd(input logic [BW-1:0] a,
                                         input logic [BW-1:0] b,
                                         input logic cin);
    logic [BW:0] r;
    logic [4:0]  s;
    logic        c;
    c = cin;
    r = '0;
    for (int i = 0; i < TD; i++) begin
      s = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0000, c};
      if (s > 5'd9) begin
        s = s + 5'd6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      r[4*i +: 4] = s[3:0];
    end
    r[BW] = c;
    return r;
  endfunction

  function automatic logic [BW-1:0] nines(input logic [BW-1:0] a);
    logic [BW-1:0] r;
    for (int i = 0; i < TD; i++) r[4*i +: 4] = 4'd9 - a[4*i +: 4];
    return r;
  endfunction

  logic [HB-1:0] upperQ, lowerQ;
  logic          signQ;
  logic [BW-1:0] baseMag, opMag, resMag;
  logic          baseSign, effSign, resSign;
  logic [BW:0]   sumW, negW;

  always_comb begin
    baseMag  = stb.resetFirst ? '0 : {upperQ, lowerQ};
    baseSign = stb.resetFirst ? 1'b0 : signQ;
    opMag    = stb.toUpper ? {opDigits, {HB{1'b0}}} : {{HB{1'b0}}, opDigits};
    effSign  = opSign ^ stb.negate;
    sumW     = '0;
    negW     = '0;
    if (baseSign == effSign) begin
      sumW    = bcdAdd(baseMag, opMag, 1'b0);
      resMag  = sumW[BW-1:0];
      resSign = effSign;
    end else begin
      sumW = bcdAdd(baseMag, nines(opMag), 1'b1);
      if (sumW[BW]) begin
        resMag  = sumW[BW-1:0];
        resSign = baseSign;
      end else begin
        negW    = bcdAdd(nines(sumW[BW-1:0]), '0, 1'b1);
        resMag  = negW[BW-1:0];
        resSign = effSign;
      end
    end
    if (resMag == '0) resSign = stb.resetFirst ? 1'b0 : effSign;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      lowerQ <= '0;
      signQ  <= 1'b0;
    end else if (stb.apply) begin
      upperQ <= resMag[BW-1:HB];
      lowerQ <= resMag[HB-1:0];
      signQ  <= resSign;
    end else begin
      if (stb.clrUpper) upperQ <= '0;
      if (stb.clrLower) lowerQ <= '0;
    end
  end

  assign upperOut = upperQ;
  assign lowerOut = lowerQ;
  assign signOut  = signQ;

endmodule

// File: rtl/acc_split_decimal.sv
module accSplitDecimal
  import acc_pkg::*;
#(
  parameter int N = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [3:0]      opSel,
  input  logic            opSign,
  input  logic [4*N-1:0]  opDigits,
  output logic [4*N-1:0]  upperOut,
  output logic [4*N-1:0]  lowerOut,
  output logic            signOut,
  output logic            done,
  output logic            errFlag
);

  accStrobes_t stb;

  accCtrl #(.N(N)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .opDigits(opDigits), .stb(stb), .done(done), .errFlag(errFlag)
  );

  accDatapath #(.N(N)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .opSign(opSign),
    .opDigits(opDigits), .upperOut(upperOut), .lowerOut(lowerOut),
    .signOut(signOut)
  );

endmodule

// File: rtl/acc_checker.sv
module accChecker #(
  parameter int N = 10
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic [3:0]     opSel,
  input logic [4*N-1:0] upperOut,
  input logic [4*N-1:0] lowerOut,
  input logic           signOut,
  input logic           done,
  input logic           errFlag
);

  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  p_no_done_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(upperOut) && $stable(lowerOut) && $stable(signOut)));

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> ($stable(upperOut) && $stable(lowerOut) && $stable(signOut)));

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> done);

  p_reset_zero_plus_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel[3:2] == 2'b01) |=>
      (errFlag || !signOut || upperOut != '0 || lowerOut != '0));

  p_reset_lower_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel[3:1] == 3'b010) |=> (errFlag || upperOut == '0));

  p_reset_upper_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel[3:1] == 3'b011) |=> (errFlag || lowerOut == '0));

  p_clr_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel == 4'h8) |=>
      (upperOut == '0 && $stable(lowerOut) && $stable(signOut)));

  p_clr_lower_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel == 4'h9) |=>
      (lowerOut == '0 && $stable(upperOut) && $stable(signOut)));

endmodule

bind accSplitDecimal accChecker #(.N(N)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
  .upperOut(upperOut), .lowerOut(lowerOut), .signOut(signOut),
  .done(done), .errFlag(errFlag)
);

// File: tb/tb_accSplitDecimal.sv
module tb_accSplitDecimal;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opSel = '0;
  logic        opSign = 1'b0;
  logic [39:0] opDigits = '0;
  logic [39:0] upperOut, lowerOut;
  logic        signOut, done, errFlag;
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  accSplitDecimal dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .opSign(opSign),
    .opDigits(opDigits), .upperOut(upperOut), .lowerOut(lowerOut),
    .signOut(signOut), .done(done), .errFlag(errFlag)
  );

  task automatic cmp(input string req, input logic [39:0] act, input logic [39:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic state(input string req, input logic [39:0] u, input logic [39:0] l,
                       input logic s);
    cmp({req, " upper"}, upperOut, u);
    cmp({req, " lower"}, lowerOut, l);
    cmp({req, " sign"}, {39'b0, signOut}, {39'b0, s});
  endtask

  task automatic runOp(input logic [3:0] op, input logic sg, input logic [39:0] d);
    @(negedge clk);
    opSel = op; opSign = sg; opDigits = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic tReset();
    state("R1 reset", '0, '0, 1'b0);
    cmp("R1 done", {39'b0, done}, '0);
    cmp("R1 err", {39'b0, errFlag}, '0);
  endtask

  task automatic tLowerCarry();
    runOp(4'h4, 1'b0, 40'h0000000123);
    state("R6 reset-add lower", '0, 40'h0000000123, 1'b0);
    cmp("R2 done pulse", {39'b0, done}, 40'h1);
    runOp(4'h0, 1'b0, 40'h9999999999);
    state("R3 carry into upper", 40'h1, 40'h0000000122, 1'b0);
    runOp(4'h1, 1'b0, 40'h0000000200);
    state("R3 borrow from upper", '0, 40'h9999999922, 1'b0);
    runOp(4'h1, 1'b0, 40'h9999999999);
    state("R3 sign reversal lower", '0, 40'h77, 1'b1);
  endtask

  task automatic tUpper();
    runOp(4'h6, 1'b0, 40'h5);
    state("R6 reset-add upper", 40'h5, '0, 1'b0);
    runOp(4'h0, 1'b0, 40'h300);
    state("R3 add lower", 40'h5, 40'h300, 1'b0);
    runOp(4'h3, 1'b0, 40'h2);
    state("R4 upper sub keeps lower", 40'h3, 40'h300, 1'b0);
    runOp(4'h3, 1'b0, 40'h7);
    state("R5 reversal complements lower", 40'h3, 40'h9999999700, 1'b1);
    runOp(4'h7, 1'b0, 40'h0);
    state("R7 reset zero is plus", '0, '0, 1'b0);
  endtask

  task automatic tZeroSign();
    runOp(4'h4, 1'b0, 40'h5);
    runOp(4'h1, 1'b0, 40'h5);
    state("R7 zero takes effective sign", '0, '0, 1'b1);
    runOp(4'h6, 1'b0, 40'h2);
    runOp(4'h3, 1'b0, 40'h3);
    state("R5 reversal with zero lower", 40'h1, '0, 1'b1);
  endtask

  task automatic tClear();
    runOp(4'h1, 1'b0, 40'h5);
    state("R3 minus grows", 40'h1, 40'h5, 1'b1);
    runOp(4'h8, 1'b0, 40'h9999999999);
    state("R8 clear upper", '0, 40'h5, 1'b1);
    runOp(4'h6, 1'b0, 40'h4);
    runOp(4'h0, 1'b0, 40'h6);
    runOp(4'h9, 1'b1, 40'h1);
    state("R8 clear lower", 40'h4, '0, 1'b0);
  endtask

  task automatic tErrAndUnused();
    runOp(4'h0, 1'b0, 40'h000000000A);
    cmp("R9 err flag", {39'b0, errFlag}, 40'h1);
    cmp("R9 done with err", {39'b0, done}, 40'h1);
    state("R9 state kept", 40'h4, '0, 1'b0);
    runOp(4'hC, 1'b1, 40'h1);
    cmp("R10 done", {39'b0, done}, 40'h1);
    cmp("R10 no err", {39'b0, errFlag}, '0);
    state("R10 state kept", 40'h4, '0, 1'b0);
    @(negedge clk);
    cmp("R2 idle no done", {39'b0, done}, '0);
    state("R2 idle hold", 40'h4, '0, 1'b0);
  endtask

  task automatic tOverflow();
    runOp(4'h6, 1'b0, 40'h9999999999);
    runOp(4'h2, 1'b0, 40'h1);
    state("R4 top carry dropped", '0, '0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLowerCarry();
    tUpper();
    tZeroSign();
    tClear();
    tErrAndUnused();
    tOverflow();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule